// File: doc/BRIEF.md
# Field-Proportional PWM Duty Generator

This block turns a filtered, signed magnetic-field sample into a pulse-width-modulated output bit. The duty cycle is a programmed quiescent level plus the field scaled by a sensitivity gain. The result is limited to a low and a high diagnostic level, so a stuck or shorted line can be told apart from a valid reading. The carrier period is a count of system-clock ticks. A coarse range bit and a fine code choose it.

Two operating shapes are supported. In bidirectional mode the quiescent level sits near mid-scale and follows the field both ways. In unidirectional mode the quiescent level sits near the low end and only positive field raises it. The period length and the high time are captured together when a period starts, so the output changes only on carrier boundaries.

An optional power-up calibration window holds the output at the quiescent duty for a fixed number of carrier periods after reset, whatever the field. A status bit marks the periods that are being forced this way.

Top module: `field_pwm_gen`

## Requirements
- R1: The carrier period in clock ticks is 64 − 2·fine when `rate_fast_i` is 1, and 512 − 16·fine when it is 0. Here fine is the 4-bit unsigned `rate_fine_i`.
- R2: Each period starts with the output high. The output stays high for floor(period·duty/1024) ticks and is low for the rest of the period. The duty is in units of 1/1024.
- R3: With `bidir_i` = 1, duty = 410 + qcode + floor(field·sens/64). The field is two's complement and the sensitivity and qcode are unsigned.
- R4: With `bidir_i` = 0, duty = 102 + qcode + floor(max(field,0)·sens/64). A negative field has no effect on the output.
- R5: The duty is limited to the range 77 to 947 inclusive.
- R6: The most extreme field and sensitivity values (field −2048 or 2047 with sensitivity 255) saturate at the limit on the matching side and never wrap.
- R7: Inputs are used only at the start of a period. A change during a period alters neither the length nor the high time of that period.
- R8: With `cal_en_i` = 1, the first 100 periods after reset use duty = base + qcode, ignoring the field. From period 101 on, the duty follows the field.
- R9: `cal_active_o` is 1 during each period whose duty was forced for calibration. It is 0 otherwise, including whenever `cal_en_i` is 0.
- R10: While `rst_n` is low, `pwm_o` and `cal_active_o` are 0. The first period begins on the first clock edge after release. A later reset restarts both the carrier and the calibration window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, models power-up |
| field_i | input | 12 | Filtered field sample, two's complement, positive = south |
| sens_i | input | 8 | Sensitivity gain, unsigned |
| qcode_i | input | 8 | Quiescent duty offset above the mode base |
| bidir_i | input | 1 | 1 = bidirectional, 0 = unidirectional |
| rate_fast_i | input | 1 | Carrier range: 1 = fast (short period), 0 = slow |
| rate_fine_i | input | 4 | Fine carrier code; a larger code gives a shorter period |
| cal_en_i | input | 1 | Enables the power-up calibration window |
| pwm_o | output | 1 | PWM output |
| cal_active_o | output | 1 | High while the current period is forced to quiescent duty |

## Verification
The assertions assume the carrier settings never produce a period shorter than two ticks. They also assume the unidirectional base plus the largest quiescent code stays inside the clamp band. Both assumptions hold for every fine code and qcode under the default parameters. The stimulus changes inputs only on the falling clock edge. It does so either just before a period boundary, or at a chosen tick inside a period when the boundary behaviour itself is under test. Expected high times are computed arithmetically from the duty formula across a sweep of field, sensitivity and mode values.

// File: rtl/fpwm_pkg.sv
// Shared types for the field-proportional PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package fpwm_pkg;
    typedef enum logic {
        RANGE_SLOW = 1'b0,
        RANGE_FAST = 1'b1
    } rate_range_e;

    typedef enum logic {
        SHAPE_UNI = 1'b0,
        SHAPE_BI  = 1'b1
    } field_shape_e;
endpackage

// File: rtl/fpwm_carrier.sv
// Maps the coarse range bit and the fine code to a carrier period in clock ticks.
// Assumes: BASE - (2**FINE_W - 1) * STEP >= 2 for both ranges.
module fpwm_carrier
    import fpwm_pkg::*;
#(
    parameter int FINE_W    = 4,
    parameter int PER_W     = 12,
    parameter int FAST_BASE = 64,
    parameter int FAST_STEP = 2,
    parameter int SLOW_BASE = 512,
    parameter int SLOW_STEP = 16
) (
    input  rate_range_e        range_i,
    input  logic [FINE_W-1:0]  fine_i,
    output logic [PER_W-1:0]   period_o
);
    localparam logic [PER_W-1:0] FB = PER_W'(FAST_BASE);
    localparam logic [PER_W-1:0] FS = PER_W'(FAST_STEP);
    localparam logic [PER_W-1:0] SB = PER_W'(SLOW_BASE);
    localparam logic [PER_W-1:0] SS = PER_W'(SLOW_STEP);

    logic [PER_W-1:0] fine_ext;

    // Pick the base and the step of the selected range; a larger fine code gives a shorter period.
    always_comb begin
        fine_ext = PER_W'(fine_i);
        if (range_i == RANGE_FAST)
            period_o = FB - fine_ext * FS;
        else
            period_o = SB - fine_ext * SS;
    end
endmodule

// File: rtl/fpwm_duty.sv
// Computes the clamped duty (units of 1/2**DUTY_FRAC) from field, gain and quiescent code.
// Assumes: UNI_BASE + max qcode lies within [CLAMP_LO, CLAMP_HI].
module fpwm_duty
    import fpwm_pkg::*;
#(
    parameter int FIELD_W    = 12,
    parameter int SENS_W     = 8,
    parameter int Q_W        = 8,
    parameter int DUTY_FRAC  = 10,
    parameter int SENS_SHIFT = 6,
    parameter int UNI_BASE   = 102,
    parameter int BI_BASE    = 410,
    parameter int CLAMP_LO   = 77,
    parameter int CLAMP_HI   = 947,
    localparam int DUTY_W    = DUTY_FRAC + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [FIELD_W-1:0] field_i,
    input  logic [SENS_W-1:0]         sens_i,
    input  logic [Q_W-1:0]            qcode_i,
    input  field_shape_e              shape_i,
    output logic [DUTY_W-1:0]         duty_o
);
    localparam int PROD_W = FIELD_W + SENS_W + 1;
    localparam int SUM_W  = PROD_W + 2;
    localparam logic signed [SUM_W-1:0] LO_S = SUM_W'(CLAMP_LO);
    localparam logic signed [SUM_W-1:0] HI_S = SUM_W'(CLAMP_HI);
    localparam logic signed [FIELD_W-1:0] FIELD_MIN = {1'b1, {(FIELD_W-1){1'b0}}};

    logic signed [FIELD_W-1:0] fld_eff;
    logic signed [PROD_W-1:0]  fld_ext;
    logic signed [PROD_W-1:0]  sens_ext;
    logic signed [PROD_W-1:0]  prod;
    logic signed [PROD_W-1:0]  term;
    logic signed [SUM_W-1:0]   base_s;
    logic signed [SUM_W-1:0]   sum;

    // Unidirectional shape discards negative field.
    always_comb begin
        if (shape_i == SHAPE_UNI && field_i[FIELD_W-1])
            fld_eff = '0;
        else
            fld_eff = field_i;
    end

    // Wide signed product and arithmetic shift; widths are chosen so nothing wraps.
    always_comb begin
        fld_ext  = PROD_W'(fld_eff);
        sens_ext = $signed(PROD_W'(sens_i));
        prod     = fld_ext * sens_ext;
        term     = prod >>> SENS_SHIFT;
    end

    // Quiescent level plus field term, then saturate to the diagnostic band.
    always_comb begin
        base_s = (shape_i == SHAPE_BI) ? SUM_W'(BI_BASE) : SUM_W'(UNI_BASE);
        sum    = SUM_W'(term) + base_s + $signed(SUM_W'(qcode_i));
        if (sum < LO_S)
            duty_o = DUTY_W'(CLAMP_LO);
        else if (sum > HI_S)
            duty_o = DUTY_W'(CLAMP_HI);
        else
            duty_o = DUTY_W'(sum);
    end

    assert_clamp_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_o >= DUTY_W'(CLAMP_LO)) && (duty_o <= DUTY_W'(CLAMP_HI)));

    assert_uni_negative_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shape_i == SHAPE_UNI && field_i < 0) |-> duty_o == DUTY_W'(UNI_BASE) + DUTY_W'(qcode_i));

    assert_extreme_low_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shape_i == SHAPE_BI && field_i == FIELD_MIN && sens_i == '1) |-> duty_o == DUTY_W'(CLAMP_LO));
endmodule

// File: rtl/fpwm_core.sv
// Carrier counter, boundary capture of period and high time, and calibration period counter.
// Assumes: period_i >= 2 whenever a period is loaded.
module fpwm_core #(
    parameter int PER_W       = 12,
    parameter int DUTY_FRAC   = 10,
    parameter int CAL_PERIODS = 100,
    localparam int DUTY_W     = DUTY_FRAC + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic              cal_en_i,
    output logic              cal_force_o,
    output logic              pwm_o,
    output logic              cal_active_o
);
    localparam int MULT_W = PER_W + DUTY_W;
    localparam int CAL_W  = $clog2(CAL_PERIODS + 1);
    localparam logic [CAL_W-1:0] CAL_LIM = CAL_W'(CAL_PERIODS);

    logic [PER_W-1:0]  cnt;
    logic [PER_W-1:0]  per_q;
    logic [PER_W-1:0]  high_q;
    logic [PER_W-1:0]  high_in;
    logic [MULT_W-1:0] mult;
    logic [CAL_W-1:0]  cal_cnt;
    logic              cal_q;
    logic              load;

    // High time of the next period, rounded down.
    always_comb begin
        mult    = MULT_W'(period_i) * MULT_W'(duty_i);
        high_in = PER_W'(mult >> DUTY_FRAC);
    end

    // A period boundary: the last tick, or the idle state left by reset.
    always_comb load = (per_q == '0) || (cnt == per_q - 1'b1);

    // Calibration forcing applies while fewer than CAL_PERIODS periods have been loaded.
    always_comb cal_force_o = cal_en_i && (cal_cnt < CAL_LIM);

    // Counter and capture registers; reset restarts the carrier and the calibration window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            per_q   <= '0;
            high_q  <= '0;
            cal_cnt <= '0;
            cal_q   <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            per_q  <= period_i;
            high_q <= high_in;
            cal_q  <= cal_force_o;
            if (cal_cnt != CAL_LIM)
                cal_cnt <= cal_cnt + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign pwm_o        = (cnt < high_q);
    assign cal_active_o = cal_q;

    assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(per_q) && $stable(high_q)));

    assert_low_tail_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !pwm_o) |=> !pwm_o);

    assert_high_fits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> high_in <= period_i);

    assert_min_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> period_i >= PER_W'(2));

    assert_cal_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cal_cnt <= CAL_LIM);
endmodule

// File: rtl/field_pwm_gen.sv
// Top: field-proportional PWM with diagnostic clamps, boundary-only updates and a power-up calibration window.
// Assumes: the field sample is already filtered and stable enough to be sampled once per period.
module field_pwm_gen
    import fpwm_pkg::*;
#(
    parameter int FIELD_W     = 12,
    parameter int SENS_W      = 8,
    parameter int Q_W         = 8,
    parameter int FINE_W      = 4,
    parameter int PER_W       = 12,
    parameter int DUTY_FRAC   = 10,
    parameter int SENS_SHIFT  = 6,
    parameter int UNI_BASE    = 102,
    parameter int BI_BASE     = 410,
    parameter int CLAMP_LO    = 77,
    parameter int CLAMP_HI    = 947,
    parameter int FAST_BASE   = 64,
    parameter int FAST_STEP   = 2,
    parameter int SLOW_BASE   = 512,
    parameter int SLOW_STEP   = 16,
    parameter int CAL_PERIODS = 100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic signed [FIELD_W-1:0] field_i,
    input  logic [SENS_W-1:0]         sens_i,
    input  logic [Q_W-1:0]            qcode_i,
    input  logic                      bidir_i,
    input  logic                      rate_fast_i,
    input  logic [FINE_W-1:0]         rate_fine_i,
    input  logic                      cal_en_i,
    output logic                      pwm_o,
    output logic                      cal_active_o
);
    localparam int DUTY_W = DUTY_FRAC + 1;

    logic [PER_W-1:0]          period;
    logic [DUTY_W-1:0]         duty;
    logic                      cal_force;
    logic signed [FIELD_W-1:0] field_eff;
    rate_range_e               range;
    field_shape_e              shape;

    // Translate plain port bits into the shared enumerations.
    always_comb begin
        range = rate_range_e'(rate_fast_i);
        shape = field_shape_e'(bidir_i);
    end

    // During calibration the field is replaced by zero, leaving the quiescent duty.
    always_comb field_eff = cal_force ? '0 : field_i;

    fpwm_carrier #(
        .FINE_W(FINE_W), .PER_W(PER_W),
        .FAST_BASE(FAST_BASE), .FAST_STEP(FAST_STEP),
        .SLOW_BASE(SLOW_BASE), .SLOW_STEP(SLOW_STEP)
    ) u_carrier (
        .range_i (range),
        .fine_i  (rate_fine_i),
        .period_o(period)
    );

    fpwm_duty #(
        .FIELD_W(FIELD_W), .SENS_W(SENS_W), .Q_W(Q_W),
        .DUTY_FRAC(DUTY_FRAC), .SENS_SHIFT(SENS_SHIFT),
        .UNI_BASE(UNI_BASE), .BI_BASE(BI_BASE),
        .CLAMP_LO(CLAMP_LO), .CLAMP_HI(CLAMP_HI)
    ) u_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .field_i(field_eff),
        .sens_i (sens_i),
        .qcode_i(qcode_i),
        .shape_i(shape),
        .duty_o (duty)
    );

    fpwm_core #(
        .PER_W(PER_W), .DUTY_FRAC(DUTY_FRAC), .CAL_PERIODS(CAL_PERIODS)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_i    (period),
        .duty_i      (duty),
        .cal_en_i    (cal_en_i),
        .cal_force_o (cal_force),
        .pwm_o       (pwm_o),
        .cal_active_o(cal_active_o)
    );
endmodule

// File: tb/sim_field_pwm_gen.sv
`timescale 1ns/1ps
module sim_field_pwm_gen;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [11:0] field = '0;
    logic [7:0]        sens = '0;
    logic [7:0]        qcode = '0;
    logic              bidir = 1'b1;
    logic              fast = 1'b1;
    logic [3:0]        fine = '0;
    logic              cal_en = 1'b1;
    logic              pwm_o;
    logic              cal_active_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic signed [11:0] chg_field = '0;
    logic [3:0]         chg_fine = '0;

    always #2 clk = ~clk;

    field_pwm_gen u0 (
        .clk(clk), .rst_n(rst_n), .field_i(field), .sens_i(sens), .qcode_i(qcode),
        .bidir_i(bidir), .rate_fast_i(fast), .rate_fine_i(fine), .cal_en_i(cal_en),
        .pwm_o(pwm_o), .cal_active_o(cal_active_o)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_period(input bit f, input int fn);
        return f ? (64 - 2 * fn) : (512 - 16 * fn);
    endfunction

    function automatic int exp_duty(input int fv, input int s, input int q, input bit bi, input bit forced);
        int fe = fv;
        int d;
        if (forced) fe = 0;
        if (!bi && fe < 0) fe = 0;
        d = (bi ? 410 : 102) + q + ((fe * s) >>> 6);
        if (d < 77) d = 77;
        if (d > 947) d = 947;
        return d;
    endfunction

    function automatic int exp_high(input int per, input int d);
        return (per * d) / 1024;
    endfunction

    // Samples one whole period at the falling edges, comparing the shape tick by tick.
    task automatic run_period(input int per, input int exph, input int cal_exp,
                              input string tag, input int chg_at);
        int hi = 0;
        int bad = 0;
        int cal_seen = 0;
        bit cal_bad = 1'b0;
        for (int i = 0; i < per; i++) begin
            @(negedge clk);
            if (pwm_o === 1'b1) hi++;
            if (pwm_o !== (i < exph)) bad++;
            if (cal_exp >= 0 && cal_active_o !== cal_exp[0]) begin
                cal_bad = 1'b1;
                cal_seen = int'(cal_active_o);
            end
            if (i == chg_at) begin
                field = chg_field;
                fine  = chg_fine;
            end
        end
        check(bad == 0 && hi == exph, tag, hi, exph);
        if (cal_exp >= 0)
            check(!cal_bad, {tag, " R9 cal_active"}, cal_bad ? cal_seen : cal_exp, cal_exp);
    endtask

    initial begin
        int fields[9] = '{-2048, -600, -100, -1, 0, 1, 100, 600, 2047};
        int senses[3] = '{0, 32, 255};
        int per, d;
        string tag;

        // R10: outputs low while reset is held, even with calibration enabled
        repeat (4) @(negedge clk);
        check(pwm_o === 1'b0, "R10 pwm in reset", int'(pwm_o), 0);
        check(cal_active_o === 1'b0, "R10 cal_active in reset", int'(cal_active_o), 0);

        // First period after release, bidirectional, calibration off
        cal_en = 1'b0; bidir = 1'b1; fast = 1'b1; fine = 4'd0; qcode = 8'd102; sens = 8'd64; field = 12'sd0;
        rst_n = 1'b1;
        per = exp_period(1'b1, 0);
        run_period(per, exp_high(per, exp_duty(0, 64, 102, 1'b1, 1'b0)), 0, "R10 first period", -1);

        // R3 R4 R5 R6: sweep over shape, gain and field
        qcode = 8'd40;
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 3; s++) begin
                for (int k = 0; k < 9; k++) begin
                    bidir = m[0];
                    sens  = 8'(senses[s]);
                    field = 12'(fields[k]);
                    d = exp_duty(fields[k], senses[s], 40, m[0], 1'b0);
                    if (senses[s] == 255 && (fields[k] == -2048 || fields[k] == 2047)) tag = "R6 extreme";
                    else if (d == 77 || d == 947) tag = "R5 clamp";
                    else if (m == 0) tag = "R4 unidirectional";
                    else tag = "R3 bidirectional";
                    run_period(per, exp_high(per, d), 0, tag, -1);
                end
            end
        end

        // R1: carrier period across ranges and fine codes
        bidir = 1'b1; sens = 8'd64; qcode = 8'd0; field = 12'sd300;
        d = exp_duty(300, 64, 0, 1'b1, 1'b0);
        foreach (fields[j]) begin
            if (j < 5) begin
                fast = (j < 3);
                fine = (j == 0 || j == 3) ? 4'd0 : (j == 1 ? 4'd7 : 4'd15);
                per = exp_period(fast, int'(fine));
                run_period(per, exp_high(per, d), 0, "R1 R2 period", -1);
            end
        end

        // R7: mid-period change leaves the current period untouched
        fast = 1'b1; fine = 4'd0; field = 12'sd0; sens = 8'd64;
        per = exp_period(1'b1, 0);
        d = exp_duty(0, 64, 0, 1'b1, 1'b0);
        run_period(per, exp_high(per, d), 0, "R7 settle", -1);
        chg_field = 12'sd2047; chg_fine = 4'd15;
        run_period(per, exp_high(per, d), 0, "R7 mid-period change", 5);
        per = exp_period(1'b1, 15);
        run_period(per, exp_high(per, exp_duty(2047, 64, 0, 1'b1, 1'b0)), 0, "R7 next boundary", -1);

        // R8 R9 R10: reset restarts the calibration window
        rst_n = 1'b0;
        cal_en = 1'b1; fine = 4'd0; qcode = 8'd50; field = 12'sd1500; sens = 8'd64; bidir = 1'b1;
        repeat (3) @(negedge clk);
        check(pwm_o === 1'b0, "R10 pwm in second reset", int'(pwm_o), 0);
        rst_n = 1'b1;
        per = exp_period(1'b1, 0);
        for (int p = 1; p <= 100; p++)
            run_period(per, exp_high(per, exp_duty(1500, 64, 50, 1'b1, 1'b1)), 1, "R8 forced period", -1);
        run_period(per, exp_high(per, exp_duty(1500, 64, 50, 1'b1, 1'b0)), 0, "R8 tracking after window", -1);
        field = -12'sd1000;
        run_period(per, exp_high(per, exp_duty(-1000, 64, 50, 1'b1, 1'b0)), 0, "R8 tracking north", -1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL R2 watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule